// File: doc/BRIEF.md
# Configuration Word Lookup and Software/Firmware Semaphore Registers

This block is a small memory-mapped register set on a 32-bit register bus. It contains three independent functions. The first is a lookup register that fetches one 16-bit word from an on-chip store of 64 configuration words. The second is a pair of semaphore registers shared between driver software and management firmware. The third is a plain 32-bit sync register that both sides may use by convention.

Software starts a lookup by writing the lookup register with its start bit set and a word index. On the next cycle the register already holds the result: the fetched word, the done flag set and start cleared. An index outside the store is reported on a dedicated error output.

The software semaphore register sets its grab bit as a side effect of every read, so the first reader sees it clear and owns the resource. A software write cannot take the EEPROM-ownership bit while the firmware holds its own semaphore. The firmware register is driven from a firmware-side input and is read-only on the bus. The word store is filled through a separate preload port.

Top module: `cfgw_regs`

## Requirements
- R1: After reset every register reads 0 (lookup register, software semaphore, firmware semaphore, sync register) and `wordrd_err` is 0.
- R2: A write to offset 0x0014 with bit 0 (start) set performs a lookup. From the next cycle that register reads {word[31:16] = store[index], index[15:2] = written index, bit 1 (done) = 1, bit 0 (start) = 0}. The written bits 31:16 and bit 1 are discarded.
- R3: A lookup whose index (bits 15:2) is 64 or more sets `wordrd_err` to 1, leaves bits 31:16 at 0 and still sets done. A later lookup with a legal index clears `wordrd_err`.
- R4: A write to 0x0014 with bit 0 clear stores the written 32-bit value unchanged, performs no lookup and leaves `wordrd_err` unchanged.
- R5: A read of the software semaphore at 0x5B50 returns its present value. The read then sets bit 0 (grab bit), so a second read returns bit 0 = 1.
- R6: A write to 0x5B50 stores bits 2:0 (bit 0 grab, bit 1 software EEPROM ownership, bit 2 wake). Bits 31:3 always read 0, and writing 0 to bit 0 clears the grab bit.
- R7: While bit 0 of the firmware semaphore register is 1, a software write to 0x5B50 stores bit 1 as 0 and stores bits 0 and 2 as written.
- R8: The firmware semaphore at 0x5B54 reads the `fw_status` input as sampled at the previous clock edge, masked to its defined fields: bit 0 semaphore, bits 3:1 mode, bit 15 valid, bits 18:16 reset count, bits 24:19 error indication (mask 0x01FF800F). Bus writes to it have no effect.
- R9: The sync register at 0x5B5C is a plain 32-bit read/write register.
- R10: A preload write sets store[`pl_idx`] to `pl_word`, and a later lookup returns it. Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe; read side effects apply at the clock edge |
| bus_addr | input | 16 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd`; 0 otherwise |
| pl_we | input | 1 | Preload write enable for the word store |
| pl_idx | input | 6 | Preload word index |
| pl_word | input | 16 | Preload word value |
| fw_status | input | 32 | Firmware-driven value of the firmware semaphore register |
| wordrd_err | output | 1 | Last lookup used an index outside the store |

## Verification
The hardest situation to reach is the interaction of the two semaphore registers. The ownership override needs the firmware semaphore already captured from `fw_status` before the software write lands, and the grab bit's set-on-read needs a read that returns the old value while changing it at the same edge. The bench first sets `fw_status` and waits one edge. It then writes the software register and reads it back twice, so both the pre-set value and the post-read value are observed. Lookups are driven at index 0, 63, 64 and a far out-of-range index, each with garbage in the data and done fields.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int BUS_W  = 32;
  localparam int OFS_W  = 16;
  localparam int WORD_W = 16;
  localparam int IDX_FIELD_W = 14;

  localparam logic [OFS_W-1:0] OFS_LOOKUP = 16'h0014;
  localparam logic [OFS_W-1:0] OFS_SWSEM  = 16'h5B50;
  localparam logic [OFS_W-1:0] OFS_FWSEM  = 16'h5B54;
  localparam logic [OFS_W-1:0] OFS_SYNC   = 16'h5B5C;

  // defined firmware fields: sem(0) mode(3:1) valid(15) rstcnt(18:16) err(24:19)
  localparam logic [BUS_W-1:0] FW_FIELD_MASK = 32'h01FF_800F;

  typedef struct packed {
    logic [WORD_W-1:0]      word;
    logic [IDX_FIELD_W-1:0] index;
    logic                   done;
    logic                   start;
  } lookup_reg_t;

  function automatic logic index_legal(logic [IDX_FIELD_W-1:0] idx, int depth);
    return int'(idx) < depth;
  endfunction

  function automatic lookup_reg_t lookup_result(logic [IDX_FIELD_W-1:0] idx,
                                               logic [WORD_W-1:0] w, logic ok);
    lookup_reg_t r;
    r.word  = ok ? w : '0;
    r.index = idx;
    r.done  = 1'b1;
    r.start = 1'b0;
    return r;
  endfunction

  function automatic logic [2:0] swsem_next(logic [2:0] wr, logic fw_hold);
    return {wr[2], wr[1] & ~fw_hold, wr[0]};
  endfunction
endpackage

// File: rtl/cfgw_word_store.sv
module cfgw_word_store #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_we,
  input  logic [IDX_W-1:0]  pl_idx,
  input  logic [WORD_W-1:0] pl_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) mem[i] <= '0;
      else if (pl_we && (int'(pl_idx) == i)) mem[i] <= pl_word;
    end
  end

  assign rd_word = mem[rd_idx];

  // R10: preloaded word is present on the next cycle
  a_r10_preload_lands: assert property (@(posedge clk) disable iff (!rst_n)
    pl_we |=> mem[$past(pl_idx)] == $past(pl_word));
endmodule

// File: rtl/cfgw_lookup.sv
module cfgw_lookup
  import cfgw_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wdata,
  output logic [IDX_W-1:0]  store_idx,
  input  logic [WORD_W-1:0] store_word,
  output logic [BUS_W-1:0]  reg_q,
  output logic              err
);
  lookup_reg_t q;
  logic start_req;
  logic idx_ok;
  logic [IDX_FIELD_W-1:0] wr_idx;

  assign wr_idx    = wdata[2 +: IDX_FIELD_W];
  assign start_req = wr_en & wdata[0];
  assign idx_ok    = index_legal(wr_idx, DEPTH);
  assign store_idx = wr_idx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      err <= 1'b0;
    end else if (start_req) begin
      q   <= lookup_result(wr_idx, store_word, idx_ok);
      err <= ~idx_ok;
    end else if (wr_en) begin
      q <= lookup_reg_t'(wdata);
    end
  end

  assign reg_q = BUS_W'(q);

  // R2: a start write leaves done set and start clear
  a_r2_start_completes: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (reg_q[1] && !reg_q[0]));
  // R3: an out-of-range index raises the error with a zero word
  a_r3_illegal_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && (int'(wdata[15:2]) >= DEPTH)) |=> (err && reg_q[31:16] == '0));
  // R4: a plain write never changes the error flag
  a_r4_plain_keeps_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[0]) |=> $stable(err));
endmodule

// File: rtl/cfgw_sema.sv
module cfgw_sema
  import cfgw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic             sw_rd,
  input  logic [2:0]       sw_wdata,
  input  logic [BUS_W-1:0] fw_status,
  output logic [2:0]       sw_q,
  output logic [BUS_W-1:0] fw_q
);
  logic fw_hold;
  assign fw_hold = fw_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) fw_q <= '0;
    else        fw_q <= fw_status & FW_FIELD_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sw_q <= '0;
    else if (sw_wr) sw_q <= swsem_next(sw_wdata, fw_hold);
    else if (sw_rd) sw_q[0] <= 1'b1;
  end

  // R5: a read leaves the grab bit set
  a_r5_grab_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && !sw_wr) |=> sw_q[0]);
  // R6: a write stores the grab bit as written
  a_r6_grab_written: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> sw_q[0] == $past(sw_wdata[0]));
  // R7: firmware holding its semaphore blocks software ownership
  a_r7_fw_override: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && fw_q[0]) |=> !sw_q[1]);
endmodule

// File: rtl/cfgw_regs.sv
module cfgw_regs
  import cfgw_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              pl_we,
  input  logic [IDX_W-1:0]  pl_idx,
  input  logic [WORD_W-1:0] pl_word,
  input  logic [BUS_W-1:0]  fw_status,
  output logic              wordrd_err
);
  logic hit_lookup, hit_swsem, hit_fwsem, hit_sync;
  logic [IDX_W-1:0]  store_idx;
  logic [WORD_W-1:0] store_word;
  logic [BUS_W-1:0]  lookup_q, fw_q, sync_q;
  logic [2:0]        sw_q;

  assign hit_lookup = bus_addr == OFS_LOOKUP;
  assign hit_swsem  = bus_addr == OFS_SWSEM;
  assign hit_fwsem  = bus_addr == OFS_FWSEM;
  assign hit_sync   = bus_addr == OFS_SYNC;

  cfgw_word_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_idx(pl_idx), .pl_word(pl_word),
    .rd_idx(store_idx), .rd_word(store_word));

  cfgw_lookup #(.DEPTH(DEPTH)) u_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr & hit_lookup), .wdata(bus_wdata),
    .store_idx(store_idx), .store_word(store_word), .reg_q(lookup_q), .err(wordrd_err));

  cfgw_sema u_sema (
    .clk(clk), .rst_n(rst_n), .sw_wr(bus_wr & hit_swsem),
    .sw_rd(bus_rd & ~bus_wr & hit_swsem), .sw_wdata(bus_wdata[2:0]),
    .fw_status(fw_status), .sw_q(sw_q), .fw_q(fw_q));

  always_ff @(posedge clk) begin
    if (!rst_n)                 sync_q <= '0;
    else if (bus_wr && hit_sync) sync_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_lookup)     bus_rdata = lookup_q;
      else if (hit_swsem) bus_rdata = {29'd0, sw_q};
      else if (hit_fwsem) bus_rdata = fw_q;
      else if (hit_sync)  bus_rdata = sync_q;
    end
  end

  // R9: sync register holds its value unless written
  a_r9_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit_sync) |=> $stable(sync_q));
  // R10: no read strobe, no read data
  a_r10_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

// File: tb/cfgw_regs_test.sv
module cfgw_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic pl_we = 1'b0;
  logic [5:0] pl_idx = '0;
  logic [15:0] pl_word = '0;
  logic [31:0] fw_status = '0;
  logic wordrd_err;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfgw_regs uut (.*);

  function automatic logic [15:0] model_word(int k);
    return 16'(k * 257) ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] model_lookup(int idx);
    logic [15:0] w = (idx < 64) ? model_word(idx) : 16'h0;
    return {w, 14'(idx), 2'b10};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(16'h0014, v); check("R1 lookup", v, 0);
    rd(16'h5B54, v); check("R1 fwsem", v, 0);
    rd(16'h5B5C, v); check("R1 sync", v, 0);
    check("R1 err", 32'(wordrd_err), 0);
  endtask

  task automatic t_preload;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      pl_we = 1'b1; pl_idx = 6'(k); pl_word = model_word(k);
    end
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic t_lookup;
    logic [31:0] v;
    int idxs[3] = '{5, 0, 63};
    foreach (idxs[i]) begin
      wr(16'h0014, {16'hFFFF, 14'(idxs[i]), 2'b11});
      rd(16'h0014, v);
      check("R2/R10 lookup", v, model_lookup(idxs[i]));
      check("R2 err clear", 32'(wordrd_err), 0);
    end
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    wr(16'h0014, {16'hBEEF, 14'd64, 2'b01});
    rd(16'h0014, v);
    check("R3 idx64", v, model_lookup(64));
    check("R3 err", 32'(wordrd_err), 1);
    wr(16'h0014, {16'h0, 14'd9000, 2'b01});
    rd(16'h0014, v);
    check("R3 idx9000", v, model_lookup(9000));
    // R4: a plain write keeps the error flag and stores raw data
    wr(16'h0014, 32'h1234_567A);
    rd(16'h0014, v);
    check("R4 raw store", v, 32'h1234_567A);
    check("R4 err kept", 32'(wordrd_err), 1);
    wr(16'h0014, {16'h0, 14'd7, 2'b01});
    check("R3 err cleared", 32'(wordrd_err), 0);
  endtask

  task automatic t_swsem;
    logic [31:0] v;
    rd(16'h5B50, v); check("R5 first read", v, 0);
    rd(16'h5B50, v); check("R5 second read", v, 1);
    wr(16'h5B50, 32'hFFFF_FFF7 | 32'h7);
    rd(16'h5B50, v); check("R6 store 7", v, 7);
    wr(16'h5B50, 32'h0);
    rd(16'h5B50, v); check("R6 clear grab", v, 0);
    rd(16'h5B50, v); check("R5 regrab", v, 1);
  endtask

  task automatic t_fw_override;
    logic [31:0] v;
    @(negedge clk); fw_status = 32'h1;
    wr(16'h5B50, 32'h7);
    rd(16'h5B50, v); check("R7 blocked", v, 32'h5);
    @(negedge clk); fw_status = 32'h0;
    wr(16'h5B50, 32'h2);
    rd(16'h5B50, v); check("R7 released", v, 32'h2);
  endtask

  task automatic t_fwsem;
    logic [31:0] v;
    @(negedge clk); fw_status = 32'hFFFF_FFFF;
    rd(16'h5B54, v); check("R8 masked", v, 32'h01FF_800F);
    wr(16'h5B54, 32'h0);
    rd(16'h5B54, v); check("R8 write ignored", v, 32'h01FF_800F);
    @(negedge clk); fw_status = 32'h0008_8006;
    rd(16'h5B54, v); check("R8 follows", v, 32'h0008_8006);
    @(negedge clk); fw_status = 32'h0;
  endtask

  task automatic t_sync;
    logic [31:0] v;
    wr(16'h5B5C, 32'hDEAD_BEEF);
    rd(16'h5B5C, v); check("R9 write", v, 32'hDEAD_BEEF);
    wr(16'h0100, 32'h1111_2222);
    rd(16'h0100, v); check("R10 unmapped read", v, 0);
    rd(16'h5B5C, v); check("R10 unmapped write", v, 32'hDEAD_BEEF);
    wr(16'h5B5C, 32'h0);
    rd(16'h5B5C, v); check("R9 clear", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_preload();
    t_lookup();
    t_illegal();
    t_swsem();
    t_fw_override();
    t_fwsem();
    t_sync();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule